// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters on a line that it samples sixteen times per bit period. The oversampling strobe comes from outside as a one-cycle enable. A character is a low start bit, 8 or 9 data bits, an optional parity bit and a high stop bit. The data bits can arrive least significant bit first or most significant bit first. A multiplexer in front of the receiver chooses the line to listen to: the external receive pin, the local transmitter's output (internal loopback), or the shared transmit pin (single-wire operation).

Each character is reported on `data_o` with a one-cycle `valid_o` strobe and per-character parity and framing error flags. The block also measures idle time as a count of consecutive high bit periods. It raises `idle_o` for one cycle when the line has been idle for a whole frame length. Software can put the receiver to sleep. While it sleeps, characters are not reported. Depending on `wake_sel_i`, it wakes on an idle line or on a character whose top data bit (the address mark) is set.

Top module: `uart_wake_rx`

## Requirements
- R1: A frame is one start bit (0), then 8 data bits when `nine_bit_i`=0 or 9 data bits when it is 1, then one stop bit. Each character raises `valid_o` for exactly one cycle. `data_o` holds the data right-aligned, with bit 8 equal to 0 in 8-bit mode, and does not change between strobes.
- R2: With `msb_first_i`=0 the first data bit on the line is data bit 0. With `msb_first_i`=1 the first data bit is the top data bit (bit 7 or bit 8).
- R3: A start bit is taken only when the majority of samples 7, 8 and 9 (counted from the first low sample) is 0. A shorter low pulse returns the receiver to hunting and reports no character.
- R4: With `par_en_i`=1, one parity bit follows the data. The data bits plus the parity bit must hold an even number of ones when `par_odd_i`=0 and an odd number when it is 1. `perr_o`=1 with the character marks a mismatch. `perr_o` is 0 when parity is disabled.
- R5: A 0 in the stop-bit position sets `ferr_o`=1 with that character. The next character is received normally.
- R6: The idle threshold is 10 + `nine_bit_i` + `par_en_i` consecutive high bit periods. `idle_o` pulses for one cycle per idle period. It re-arms only after a valid start bit, so the line being high after reset gives no pulse.
- R7: With `idle_after_stop_i`=0, high bits inside a frame after the start bit count toward idle. With `idle_after_stop_i`=1, the count restarts after every stop bit, so only high bit periods after the frame count.
- R8: A pulse on `sleep_req_i` sets `asleep_o` in the next cycle. While `asleep_o`=1, `valid_o` stays low except for the waking address-mark character.
- R9: With `wake_sel_i`=0, a sleeping receiver wakes when it reaches the idle threshold. In this case `idle_after_stop_i` is ignored and counting starts after the start bit. A sleep request restarts the idle count.
- R10: With `wake_sel_i`=1, a sleeping receiver wakes only on a character whose top data bit is 1. That character is delivered, `asleep_o` clears in the same cycle as its `valid_o`, and an idle line does not wake the receiver.
- R11: With `loop_en_i`=0 the receiver listens to `rxd_i`. With `loop_en_i`=1 it listens to `tx_loop_i` when `src_sel_i`=0 and to `txpin_i` when `src_sel_i`=1. Lines that are not selected have no effect.
- R12: While reset is asserted, `valid_o`, `idle_o`, `asleep_o`, `perr_o`, `ferr_o` and `data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud16_i | input | 1 | Oversampling enable, 16 per bit period |
| rxd_i | input | 1 | External receive line |
| tx_loop_i | input | 1 | Local transmitter output, for internal loopback |
| txpin_i | input | 1 | Shared transmit pin, for single-wire mode |
| loop_en_i | input | 1 | 1: take the receiver input from the loop sources |
| src_sel_i | input | 1 | Loop source: 0 transmitter output, 1 transmit pin |
| nine_bit_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| msb_first_i | input | 1 | 1: top data bit sent first |
| idle_after_stop_i | input | 1 | 1: idle count starts after the stop bit |
| wake_sel_i | input | 1 | Wake source: 0 idle line, 1 address mark |
| sleep_req_i | input | 1 | One-cycle pulse that puts the receiver to sleep |
| data_o | output | 9 | Last delivered character |
| valid_o | output | 1 | One-cycle strobe per delivered character |
| idle_o | output | 1 | One-cycle pulse when the line goes idle |
| perr_o | output | 1 | Parity error of the delivered character |
| ferr_o | output | 1 | Framing error of the delivered character |
| asleep_o | output | 1 | Receiver is sleeping |

## Verification
The hardest case to reach is the one where the idle-count start point decides the outcome. An all-ones character followed by a gap of only five bit periods reaches the threshold when counting starts after the start bit, but not when it starts after the stop bit. The bench sends this pattern once in each mode and once while asleep in idle-wake mode, where the after-stop setting must be ignored. In the sleep case, whether the following character is delivered shows which count was used.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // Per-cycle events handed from the framer to the idle/sleep unit.
  typedef struct packed {
    logic start_edge;  // first low sample seen while hunting
    logic start_ok;    // start bit passed the vote
    logic bit_evt;     // a data, parity or stop bit was decided
    logic bit_val;     // its voted value
    logic frame_end;   // stop bit decided
    logic hunt_one;    // one full high bit period while hunting
  } rx_evt_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_wake_rx_insel.sv
module uart_wake_rx_insel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic tx_loop_i,
  input  logic txpin_i,
  input  logic loop_en_i,
  input  logic src_sel_i,
  output logic rx_o
);

  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    if (!loop_en_i) raw = rxd_i;
    else if (src_sel_i) raw = txpin_i;
    else raw = tx_loop_i;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], raw};
    end else begin : g_single
      always_comb sync_d = raw;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else sync_q <= sync_d;
  end

  assign rx_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/uart_wake_rx_frame.sv
module uart_wake_rx_frame
  import uart_wake_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          nine_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          msb_first_i,
  output rx_evt_t       evt_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          mark_o
);

  localparam int PH_W  = $clog2(OSR);
  localparam int IDX_W = $clog2(DW) + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] SMP_A   = PH_W'(OSR / 2 - 1);
  localparam logic [PH_W-1:0] SMP_B   = PH_W'(OSR / 2);
  localparam logic [PH_W-1:0] SMP_C   = PH_W'(OSR / 2 + 1);

  rx_state_e        state_q, state_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             s_a_q, s_a_d, s_b_q, s_b_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic             pacc_q, pacc_d;
  logic             pbad_q, pbad_d;
  logic             done_q, done_d;
  logic [DW-1:0]    data_q, data_d;
  logic             perr_q, perr_d, ferr_q, ferr_d;
  logic             vote;
  logic [IDX_W-1:0] last_idx;
  logic [DW-1:0]    assembled;
  rx_evt_t          evt;

  assign vote     = vote3(s_a_q, s_b_q, rx_i);
  assign last_idx = nine_i ? IDX_W'(DW - 1) : IDX_W'(DW - 2);

  always_comb begin
    if (nine_i) assembled = sh_q;
    else if (msb_first_i) assembled = {1'b0, sh_q[DW-2:0]};
    else assembled = {1'b0, sh_q[DW-1:1]};
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    s_a_d   = s_a_q;
    s_b_d   = s_b_q;
    sh_d    = sh_q;
    pacc_d  = pacc_q;
    pbad_d  = pbad_q;
    done_d  = 1'b0;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    evt     = '0;
    if (tick_i) begin
      if (state_q == ST_HUNT) begin
        if (!rx_i) begin
          state_d        = ST_START;
          phase_d        = PH_W'(1);
          evt.start_edge = 1'b1;
        end else begin
          phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
          if (phase_q == PH_LAST) evt.hunt_one = 1'b1;
        end
      end else begin
        phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        if (phase_q == SMP_A) s_a_d = rx_i;
        if (phase_q == SMP_B) s_b_d = rx_i;
        if (phase_q == SMP_C) begin
          unique case (state_q)
            ST_START: begin
              if (vote) begin
                state_d = ST_HUNT;
                phase_d = '0;
              end else begin
                evt.start_ok = 1'b1;
                state_d      = ST_DATA;
                idx_d        = '0;
                pacc_d       = 1'b0;
                pbad_d       = 1'b0;
              end
            end
            ST_DATA: begin
              evt.bit_evt = 1'b1;
              evt.bit_val = vote;
              sh_d   = msb_first_i ? {sh_q[DW-2:0], vote} : {vote, sh_q[DW-1:1]};
              pacc_d = pacc_q ^ vote;
              idx_d  = idx_q + 1'b1;
              if (idx_q == last_idx) state_d = par_en_i ? ST_PAR : ST_STOP;
            end
            ST_PAR: begin
              evt.bit_evt = 1'b1;
              evt.bit_val = vote;
              pbad_d      = pacc_q ^ vote ^ par_odd_i;
              state_d     = ST_STOP;
            end
            default: begin
              evt.bit_evt   = 1'b1;
              evt.bit_val   = vote;
              evt.frame_end = 1'b1;
              done_d        = 1'b1;
              data_d        = assembled;
              perr_d        = par_en_i & pbad_q;
              ferr_d        = ~vote;
              state_d       = ST_HUNT;
              phase_d       = '0;
            end
          endcase
        end
      end
    end
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      phase_q <= '0;
      idx_q   <= '0;
      s_a_q   <= 1'b1;
      s_b_q   <= 1'b1;
      sh_q    <= '0;
      pacc_q  <= 1'b0;
      pbad_q  <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      s_a_q   <= s_a_d;
      s_b_q   <= s_b_d;
      sh_q    <= sh_d;
      pacc_q  <= pacc_d;
      pbad_q  <= pbad_d;
      done_q  <= done_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign evt_o  = evt;
  assign done_o = done_q;
  assign data_o = data_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign mark_o = nine_i ? data_q[DW-1] : data_q[DW-2];

endmodule

// File: rtl/uart_wake_rx_idle.sv
module uart_wake_rx_idle
  import uart_wake_rx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  rx_evt_t evt_i,
  input  logic    nine_i,
  input  logic    par_en_i,
  input  logic    idle_after_stop_i,
  input  logic    wake_sel_i,
  input  logic    sleep_req_i,
  input  logic    done_i,
  input  logic    mark_i,
  output logic    idle_o,
  output logic    asleep_o
);

  localparam int CNT_W = $clog2(DW + 4);
  localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(DW + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr;
  logic             armed_q, armed_d;
  logic             idle_q, idle_d;
  logic             asleep_q, asleep_d;
  logic             from_start, inc, hit;

  assign thr        = BASE_LEN + CNT_W'(nine_i) + CNT_W'(par_en_i);
  assign from_start = !idle_after_stop_i || (asleep_q && !wake_sel_i);

  // next-state process
  always_comb begin
    cnt_d = cnt_q;
    inc   = 1'b0;
    if (sleep_req_i || evt_i.start_edge) begin
      cnt_d = '0;
    end else if (evt_i.frame_end && !from_start) begin
      cnt_d = '0;
    end else if (evt_i.bit_evt && from_start) begin
      if (evt_i.bit_val) inc = 1'b1;
      else cnt_d = '0;
    end else if (evt_i.hunt_one) begin
      inc = 1'b1;
    end
    if (inc && (cnt_q < thr)) cnt_d = cnt_q + 1'b1;
    hit = inc && (cnt_q == thr - 1'b1);

    armed_d = armed_q;
    idle_d  = hit && armed_q;
    if (evt_i.start_ok) armed_d = 1'b1;
    if (idle_d) armed_d = 1'b0;

    asleep_d = asleep_q;
    if (sleep_req_i) asleep_d = 1'b1;
    else if (asleep_q && !wake_sel_i && hit) asleep_d = 1'b0;
    else if (asleep_q && wake_sel_i && done_i && mark_i) asleep_d = 1'b0;
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      idle_q   <= 1'b0;
      asleep_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      armed_q  <= armed_d;
      idle_q   <= idle_d;
      asleep_q <= asleep_d;
    end
  end

  assign idle_o   = idle_q;
  assign asleep_o = asleep_q;

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud16_i,
  input  logic          rxd_i,
  input  logic          tx_loop_i,
  input  logic          txpin_i,
  input  logic          loop_en_i,
  input  logic          src_sel_i,
  input  logic          nine_bit_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          msb_first_i,
  input  logic          idle_after_stop_i,
  input  logic          wake_sel_i,
  input  logic          sleep_req_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          idle_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          asleep_o
);

  logic [1:0]    rst_pipe_q;
  logic          rst_n_int;
  logic          rx_line;
  rx_evt_t       evt;
  logic          fr_done, fr_perr, fr_ferr, fr_mark;
  logic [DW-1:0] fr_data;
  logic          asleep;
  logic          deliver;
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          perr_q, ferr_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  uart_wake_rx_insel #(.SYNC_STAGES(SYNC_STAGES)) u_insel (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .rxd_i     (rxd_i),
    .tx_loop_i (tx_loop_i),
    .txpin_i   (txpin_i),
    .loop_en_i (loop_en_i),
    .src_sel_i (src_sel_i),
    .rx_o      (rx_line)
  );

  uart_wake_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .tick_i      (baud16_i),
    .rx_i        (rx_line),
    .nine_i      (nine_bit_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .msb_first_i (msb_first_i),
    .evt_o       (evt),
    .done_o      (fr_done),
    .data_o      (fr_data),
    .perr_o      (fr_perr),
    .ferr_o      (fr_ferr),
    .mark_o      (fr_mark)
  );

  uart_wake_rx_idle #(.DW(DW)) u_idle (
    .clk_i             (clk_i),
    .rst_ni            (rst_n_int),
    .evt_i             (evt),
    .nine_i            (nine_bit_i),
    .par_en_i          (par_en_i),
    .idle_after_stop_i (idle_after_stop_i),
    .wake_sel_i        (wake_sel_i),
    .sleep_req_i       (sleep_req_i),
    .done_i            (fr_done),
    .mark_i            (fr_mark),
    .idle_o            (idle_o),
    .asleep_o          (asleep)
  );

  assign deliver = fr_done && (!asleep || (wake_sel_i && fr_mark));

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= deliver;
      if (deliver) begin
        data_q <= fr_data;
        perr_q <= fr_perr;
        ferr_q <= fr_ferr;
      end
    end
  end

  assign valid_o  = valid_q;
  assign data_o   = data_q;
  assign perr_o   = perr_q;
  assign ferr_o   = ferr_q;
  assign asleep_o = asleep;

endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk #(
  parameter int DW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_o,
  input logic          idle_o,
  input logic          asleep_o,
  input logic          sleep_req_i,
  input logic          wake_sel_i,
  input logic [DW-1:0] data_o
);

  // R1
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R1
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  // R6
  idle_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> !idle_o);

  // R8
  sleep_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_i |=> asleep_o);

  // R8
  asleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && !wake_sel_i && !$past(sleep_req_i)) |-> !valid_o);

  // R10
  mark_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(asleep_o) && wake_sel_i) |-> valid_o);

endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_o     (valid_o),
  .idle_o      (idle_o),
  .asleep_o    (asleep_o),
  .sleep_req_i (sleep_req_i),
  .wake_sel_i  (wake_sel_i),
  .data_o      (data_o)
);

// File: tb/uart_wake_rx_bench.sv
module uart_wake_rx_bench;

  localparam int BIT_CLK = 32;  // oversampling tick every second clock

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud16 = 1'b0;
  logic rxd = 1'b1, txl = 1'b1, txp = 1'b1;
  logic loop_en = 1'b0, src_sel = 1'b0;
  logic nine = 1'b0, pe = 1'b0, odd = 1'b0, msbf = 1'b0;
  logic ilt = 1'b0, wake = 1'b0, sleep_req = 1'b0;
  logic [8:0] data_o;
  logic valid_o, idle_o, perr_o, ferr_o, asleep_o;

  int checks = 0;
  int fails = 0;
  int idle_seen = 0;
  bit finished = 0;
  logic [10:0] exp_q[$];

  always #4 clk = ~clk;

  uart_wake_rx u_uart_wake_rx (
    .clk_i(clk), .rst_ni(rst_n), .baud16_i(baud16),
    .rxd_i(rxd), .tx_loop_i(txl), .txpin_i(txp),
    .loop_en_i(loop_en), .src_sel_i(src_sel),
    .nine_bit_i(nine), .par_en_i(pe), .par_odd_i(odd), .msb_first_i(msbf),
    .idle_after_stop_i(ilt), .wake_sel_i(wake), .sleep_req_i(sleep_req),
    .data_o(data_o), .valid_o(valid_o), .idle_o(idle_o),
    .perr_o(perr_o), .ferr_o(ferr_o), .asleep_o(asleep_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      baud16 = ~baud16;
    end
  end

  // Reference model: characters expected in order, compared every clock
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 R11 unexpected character", 32'(data_o), 32'h0);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk({ferr_o, perr_o, data_o} == e, "R1 R2 R4 R5 character",
              32'({ferr_o, perr_o, data_o}), 32'(e));
        end
      end
      if (rst_n && idle_o) idle_seen++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  task automatic drive_bit(input int path, input logic v);
    case (path)
      1: txl = v;
      2: txp = v;
      default: rxd = v;
    endcase
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic gap(input int nbits);
    rxd = 1'b1;
    txl = 1'b1;
    txp = 1'b1;
    repeat (nbits * BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input int path, input logic [8:0] d, input bit par_flip,
                            input logic stopv, input bit expect_it);
    int n;
    logic [8:0] dm;
    logic p;
    n  = nine ? 9 : 8;
    dm = nine ? d : {1'b0, d[7:0]};
    p  = (^dm) ^ odd ^ par_flip;
    if (expect_it) exp_q.push_back({~stopv, pe & par_flip, dm});
    drive_bit(path, 1'b0);
    for (int i = 0; i < n; i++) drive_bit(path, msbf ? dm[n-1-i] : dm[i]);
    if (pe) drive_bit(path, p);
    drive_bit(path, stopv);
  endtask

  task automatic sleep_pulse();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(valid_o == 0, "R12 valid", 32'(valid_o), 0);
    chk(idle_o == 0, "R12 idle", 32'(idle_o), 0);
    chk(asleep_o == 0, "R12 asleep", 32'(asleep_o), 0);
    chk(perr_o == 0 && ferr_o == 0, "R12 flags", 32'({perr_o, ferr_o}), 0);
    chk(data_o == 0, "R12 data", 32'(data_o), 0);
    rst_n = 1'b1;
    gap(20);
    // R6 not armed before any start bit
    chk(idle_seen == 0, "R6 no idle after reset", 32'(idle_seen), 0);

    // R1 8-bit, LSB first
    send_frame(0, 9'h0A5, 0, 1, 1);
    send_frame(0, 9'h03C, 0, 1, 1);
    gap(2);
    chk(exp_q.size() == 0, "R1 8-bit delivered", 32'(exp_q.size()), 0);
    gap(15);
    chk(idle_seen == 1, "R6 one idle pulse", 32'(idle_seen), 1);
    gap(30);
    chk(idle_seen == 1, "R6 no second pulse", 32'(idle_seen), 1);

    // R2 MSB first
    msbf = 1'b1;
    send_frame(0, 9'h01E, 0, 1, 1);
    nine = 1'b1;
    send_frame(0, 9'h1C2, 0, 1, 1);
    msbf = 1'b0;
    // R1 9-bit
    send_frame(0, 9'h1A5, 0, 1, 1);
    send_frame(0, 9'h0F0, 0, 1, 1);
    nine = 1'b0;
    gap(15);
    chk(exp_q.size() == 0, "R1 R2 order and width", 32'(exp_q.size()), 0);

    // R4 parity
    pe = 1'b1;
    send_frame(0, 9'h035, 0, 1, 1);
    send_frame(0, 9'h035, 1, 1, 1);
    odd = 1'b1;
    send_frame(0, 9'h035, 0, 1, 1);
    send_frame(0, 9'h0B7, 1, 1, 1);
    nine = 1'b1;
    send_frame(0, 9'h155, 0, 1, 1);
    send_frame(0, 9'h155, 1, 1, 1);
    nine = 1'b0;
    pe = 1'b0;
    odd = 1'b0;
    gap(15);
    chk(exp_q.size() == 0, "R4 parity frames", 32'(exp_q.size()), 0);

    // R5 framing error, then recovery
    send_frame(0, 9'h03C, 0, 0, 1);
    gap(3);
    send_frame(0, 9'h042, 0, 1, 1);
    gap(15);
    chk(exp_q.size() == 0, "R5 framing", 32'(exp_q.size()), 0);

    // R3 short low pulse is rejected
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    gap(15);
    chk(exp_q.size() == 0, "R3 glitch ignored", 32'(exp_q.size()), 0);
    send_frame(0, 9'h077, 0, 1, 1);
    gap(15);
    chk(exp_q.size() == 0, "R3 receiver still hunting", 32'(exp_q.size()), 0);

    // R7 idle count start point
    ilt = 1'b0;
    base = idle_seen;
    send_frame(0, 9'h0FF, 0, 1, 1);
    gap(5);
    send_frame(0, 9'h000, 0, 1, 1);
    gap(15);
    chk(idle_seen - base == 2, "R7 count after start bit", 32'(idle_seen - base), 2);
    ilt = 1'b1;
    base = idle_seen;
    send_frame(0, 9'h0FF, 0, 1, 1);
    gap(5);
    send_frame(0, 9'h000, 0, 1, 1);
    gap(15);
    chk(idle_seen - base == 1, "R7 count after stop bit", 32'(idle_seen - base), 1);

    // R9 idle wakeup ignores the after-stop setting; R8 sleeping hides data
    wake = 1'b0;
    sleep_pulse();
    chk(asleep_o == 1, "R8 asleep set", 32'(asleep_o), 1);
    send_frame(0, 9'h0FF, 0, 1, 0);
    gap(5);
    send_frame(0, 9'h05A, 0, 1, 1);
    gap(15);
    chk(asleep_o == 0, "R9 woke on idle", 32'(asleep_o), 0);
    chk(exp_q.size() == 0, "R9 R8 delivery after wake", 32'(exp_q.size()), 0);
    ilt = 1'b0;

    // R10 address-mark wakeup
    wake = 1'b1;
    sleep_pulse();
    send_frame(0, 9'h012, 0, 1, 0);
    gap(15);
    chk(asleep_o == 1, "R10 idle does not wake", 32'(asleep_o), 1);
    send_frame(0, 9'h085, 0, 1, 1);
    chk(asleep_o == 0, "R10 mark wakes", 32'(asleep_o), 0);
    send_frame(0, 9'h001, 0, 1, 1);
    gap(5);
    chk(exp_q.size() == 0, "R10 mark and next delivered", 32'(exp_q.size()), 0);
    wake = 1'b0;

    // R11 input selection
    loop_en = 1'b0;
    send_frame(1, 9'h0AA, 0, 1, 0);
    gap(5);
    chk(exp_q.size() == 0, "R11 loop source ignored", 32'(exp_q.size()), 0);
    loop_en = 1'b1;
    src_sel = 1'b0;
    send_frame(1, 9'h06B, 0, 1, 1);
    send_frame(0, 9'h011, 0, 1, 0);
    src_sel = 1'b1;
    send_frame(2, 9'h0C4, 0, 1, 1);
    gap(5);
    chk(exp_q.size() == 0, "R11 loopback and single wire", 32'(exp_q.size()), 0);
    loop_en = 1'b0;
    src_sel = 1'b0;
    gap(2);

    finish_run();
  end

endmodule